// File: doc/BRIEF.md
# Window Watchdog Supervisor with Reset Generator

This block watches a microcontroller through a window watchdog and drives an active-low reset line toward it. All timing is counted in sample ticks supplied by an external prescaler. Two mode pins set the watchdog and reset speeds, or switch the watchdog off. A filtered supply-undervoltage flag forces reset. A pair of load-current flags with hysteresis suspends the watchdog while the supervised controller draws little current.

After reset is released, the watchdog passes through an ignore window and then a long first open window. From then on it alternates between closed and open windows. The controller must deliver one trigger per open window. A trigger arriving too early (closed window) or too late (open window expires) costs one full reset delay. After that delay the sequence restarts at the ignore window. Slow timing doubles every window and delay by acting on every second tick.

Top module: `wwd_supervisor`

## Requirements
- R1: Mode pins (p1, p2) decode as: 00 fast watchdog and fast reset; 01 slow watchdog and slow reset; 10 fast watchdog and slow reset; 11 watchdog off, slow reset with `rst_n_o` held high after the delay. Fast timing advances one step per tick. Slow timing advances one step on every second tick counted since `rst`.
- R2: During and right after `rst`, `rst_n_o` is 0. It rises at the step that completes RD_TICKS reset-timing steps.
- R3: On release, an ignore window of IW_TICKS watchdog steps starts. A trigger completed inside it has no effect.
- R4: The first open window after the ignore window lasts LONG_MULT*OW_TICKS steps. If it expires without a trigger, `rst_n_o` drops at the expiring step.
- R5: A valid trigger in any open window starts a closed window of CW_TICKS steps, followed by an open window of OW_TICKS steps. Expiry of that open window drops `rst_n_o`.
- R6: A valid trigger completed inside a closed window drops `rst_n_o`.
- R7: On each watchdog step, `trig_i` is sampled. A trigger is valid when the last four samples, oldest first, are 1,1,0,0. A sample taken on the step that ends a window belongs to the following window, so a pattern whose fourth sample lands on the closing step of a closed window counts as in-window.
- R8: A `uv_i` pulse shorter than UV_FILT clocks has no effect. A pulse of UV_FILT clocks drops `rst_n_o` on the next clock.
- R9: While the filtered undervoltage persists, `rst_n_o` stays 0. After recovery, it rises after RD_TICKS reset-timing steps.
- R10: A pulse on `load_lo_i` stops the watchdog and keeps `rst_n_o` high for any length of time. A pulse on `load_hi_i` restarts the sequence at the ignore window, followed by the long first open window.
- R11: After a watchdog failure, `rst_n_o` stays 0 for RD_TICKS steps. The block then re-enters the ignore window and the long first open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock sample tick from prescaler |
| trig_i | input | 1 | Synchronized trigger from the controller |
| mode_p1_i | input | 1 | Mode pin 1 |
| mode_p2_i | input | 1 | Mode pin 2 |
| uv_i | input | 1 | Supply undervoltage flag, unfiltered |
| load_hi_i | input | 1 | Load current above turn-on threshold |
| load_lo_i | input | 1 | Load current below turn-off threshold |
| rst_n_o | output | 1 | Registered active-low reset to the controller |

## Verification
On every cycle, the assertions check the following:
- A trigger in a closed window always leads to reset.
- A trigger in the ignore window never does.
- A filtered undervoltage always pulls reset low on the next clock.
- A suspended watchdog keeps reset high.
- Reset only rises out of the hold state.
- Pattern hits and steps occur only on sample ticks.

Window lengths, the long first window, the fourth-sample boundary rule, the glitch-length threshold, the slow-mode doubling and restart after load resumption depend on counted durations. Only the bench scenarios, which count ticks against the expected lengths, can show these.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_IGNORE = 3'd1,
    ST_LONG   = 3'd2,
    ST_CLOSED = 3'd3,
    ST_OPEN   = 3'd4,
    ST_OFF    = 3'd5
  } wwd_state_t;

  localparam int CH_WD = 0;
  localparam int CH_RS = 1;
  localparam int N_CH  = 2;
endpackage

// File: rtl/wwd_timebase.sv
module wwd_timebase
  import wwd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic wd_slow_i,
  input  logic rs_slow_i,
  output logic wd_step_o,
  output logic rs_step_o
);
  logic half_q;
  logic [N_CH-1:0] slow_sel;
  logic [N_CH-1:0] step_v;

  assign slow_sel[CH_WD] = wd_slow_i;
  assign slow_sel[CH_RS] = rs_slow_i;

  always_ff @(posedge clk) begin
    if (rst)         half_q <= 1'b0;
    else if (tick_i) half_q <= ~half_q;
  end

  // each timing channel picks every tick or every second tick
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign step_v[c] = tick_i & (~slow_sel[c] | half_q);
  end

  assign wd_step_o = step_v[CH_WD];
  assign rs_step_o = step_v[CH_RS];

  a_r1_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    (wd_step_o || rs_step_o) |-> tick_i);
endmodule

// File: rtl/wwd_uv_filter.sv
module wwd_uv_filter #(
  parameter int UV_FILT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_i,
  output logic uv_fault_o
);
  localparam int UW = $clog2(UV_FILT + 1);
  localparam logic [UW-1:0] LAST = UW'(UV_FILT - 1);

  logic [UW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !uv_i) begin
      run_q      <= '0;
      uv_fault_o <= 1'b0;
    end else if (run_q == LAST) begin
      uv_fault_o <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  a_r8_fault_needs_uv: assert property (@(posedge clk) disable iff (rst)
    uv_fault_o |-> $past(uv_i));
endmodule

// File: rtl/wwd_trig_decoder.sv
module wwd_trig_decoder #(
  parameter int HI_N = 2,
  parameter int LO_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic step_i,
  input  logic smp_i,
  output logic hit_o
);
  localparam int PW = HI_N + LO_N;
  localparam logic [PW-1:0] PAT = {{HI_N{1'b1}}, {LO_N{1'b0}}};

  logic [PW-1:0] hist_q;
  logic [PW-1:0] hist_n;

  assign hist_n = {hist_q[PW-2:0], smp_i};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      hist_q <= '0;
      hit_o  <= 1'b0;
    end else if (step_i) begin
      hist_q <= hist_n;
      hit_o  <= (hist_n == PAT);
    end else begin
      hit_o  <= 1'b0;
    end
  end

  a_r7_hit_after_sample: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(step_i));
endmodule

// File: rtl/wwd_ctrl.sv
module wwd_ctrl
  import wwd_pkg::*;
#(
  parameter int RD_TICKS  = 32,
  parameter int IW_TICKS  = 64,
  parameter int OW_TICKS  = 64,
  parameter int CW_TICKS  = 64,
  parameter int LONG_MULT = 4,
  parameter int CNT_W     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic wd_step_i,
  input  logic rs_step_i,
  input  logic hit_i,
  input  logic uv_fault_i,
  input  logic wd_en_i,
  output logic clr_o,
  output logic rst_n_o
);
  localparam logic [CNT_W-1:0] RD_END = CNT_W'(RD_TICKS - 1);
  localparam logic [CNT_W-1:0] IW_END = CNT_W'(IW_TICKS - 1);
  localparam logic [CNT_W-1:0] OW_END = CNT_W'(OW_TICKS - 1);
  localparam logic [CNT_W-1:0] CW_END = CNT_W'(CW_TICKS - 1);
  localparam logic [CNT_W-1:0] LO_END = CNT_W'(OW_TICKS * LONG_MULT - 1);

  wwd_state_t st;
  logic [CNT_W-1:0] cnt;

  assign clr_o = (st == ST_HOLD) || (st == ST_OFF);

  always_ff @(posedge clk) begin
    if (rst || uv_fault_i) begin
      st      <= ST_HOLD;
      cnt     <= '0;
      rst_n_o <= 1'b0;
    end else begin
      case (st)
        ST_HOLD: begin
          if (rs_step_i) begin
            if (cnt == RD_END) begin
              cnt     <= '0;
              rst_n_o <= 1'b1;
              st      <= wd_en_i ? ST_IGNORE : ST_OFF;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_OFF: begin
          rst_n_o <= 1'b1;
          if (wd_en_i) begin
            st  <= ST_IGNORE;
            cnt <= '0;
          end
        end
        default: begin
          if (!wd_en_i) begin
            st      <= ST_OFF;
            cnt     <= '0;
            rst_n_o <= 1'b1;
          end else begin
            case (st)
              ST_IGNORE: begin
                if (wd_step_i) begin
                  if (cnt == IW_END) begin
                    st  <= ST_LONG;
                    cnt <= '0;
                  end else begin
                    cnt <= cnt + 1'b1;
                  end
                end
              end
              ST_LONG, ST_OPEN: begin
                if (hit_i) begin
                  st  <= ST_CLOSED;
                  cnt <= '0;
                end else if (wd_step_i) begin
                  if (cnt == ((st == ST_LONG) ? LO_END : OW_END)) begin
                    st      <= ST_HOLD;
                    cnt     <= '0;
                    rst_n_o <= 1'b0;
                  end else begin
                    cnt <= cnt + 1'b1;
                  end
                end
              end
              ST_CLOSED: begin
                if (hit_i) begin
                  st      <= ST_HOLD;
                  cnt     <= '0;
                  rst_n_o <= 1'b0;
                end else if (wd_step_i) begin
                  if (cnt == CW_END) begin
                    st  <= ST_OPEN;
                    cnt <= '0;
                  end else begin
                    cnt <= cnt + 1'b1;
                  end
                end
              end
              default: begin
                st      <= ST_HOLD;
                cnt     <= '0;
                rst_n_o <= 1'b0;
              end
            endcase
          end
        end
      endcase
    end
  end

  a_r6_pretrig_fails: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLOSED && hit_i && !uv_fault_i && wd_en_i) |=> !rst_n_o);
  a_r3_ignore_drops_trig: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE && hit_i && !uv_fault_i) |=> rst_n_o);
  a_r9_uv_forces_low: assert property (@(posedge clk) disable iff (rst)
    uv_fault_i |=> !rst_n_o);
  a_r10_off_keeps_high: assert property (@(posedge clk) disable iff (rst)
    (st != ST_HOLD && !wd_en_i && !uv_fault_i) |=> rst_n_o);
  a_r2_release_from_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> ($past(st) == ST_HOLD));
endmodule

// File: rtl/wwd_supervisor.sv
module wwd_supervisor #(
  parameter int RD_TICKS  = 32,
  parameter int IW_TICKS  = 64,
  parameter int OW_TICKS  = 64,
  parameter int CW_TICKS  = 64,
  parameter int LONG_MULT = 4,
  parameter int UV_FILT   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic trig_i,
  input  logic mode_p1_i,
  input  logic mode_p2_i,
  input  logic uv_i,
  input  logic load_hi_i,
  input  logic load_lo_i,
  output logic rst_n_o
);
  localparam int CNT_W = $clog2(OW_TICKS * LONG_MULT + RD_TICKS + IW_TICKS + CW_TICKS + 1);

  logic wd_off, wd_slow, rs_slow, wd_en;
  logic load_on_q;
  logic wd_step, rs_step, hit, uv_fault, clr;

  // mode decode: p1&p2 disables the watchdog; p2 slows the watchdog; either slows reset
  assign wd_off  = mode_p1_i & mode_p2_i;
  assign wd_slow = mode_p2_i;
  assign rs_slow = mode_p1_i | mode_p2_i;
  assign wd_en   = ~wd_off & load_on_q;

  // load hysteresis: turn-off threshold wins over turn-on
  always_ff @(posedge clk) begin
    if (rst)            load_on_q <= 1'b1;
    else if (load_lo_i) load_on_q <= 1'b0;
    else if (load_hi_i) load_on_q <= 1'b1;
  end

  wwd_timebase tb_i (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .wd_slow_i(wd_slow), .rs_slow_i(rs_slow),
    .wd_step_o(wd_step), .rs_step_o(rs_step)
  );

  wwd_uv_filter #(.UV_FILT(UV_FILT)) uvf_i (
    .clk(clk), .rst(rst), .uv_i(uv_i), .uv_fault_o(uv_fault)
  );

  wwd_trig_decoder #(.HI_N(2), .LO_N(2)) dec_i (
    .clk(clk), .rst(rst), .clr_i(clr), .step_i(wd_step),
    .smp_i(trig_i), .hit_o(hit)
  );

  wwd_ctrl #(
    .RD_TICKS(RD_TICKS), .IW_TICKS(IW_TICKS), .OW_TICKS(OW_TICKS),
    .CW_TICKS(CW_TICKS), .LONG_MULT(LONG_MULT), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wd_step_i(wd_step), .rs_step_i(rs_step),
    .hit_i(hit), .uv_fault_i(uv_fault), .wd_en_i(wd_en),
    .clr_o(clr), .rst_n_o(rst_n_o)
  );
endmodule

// File: tb/wwd_supervisor_tb.sv
`timescale 1ns/1ps
module wwd_supervisor_tb_top;
  localparam int RD = 3, IW = 6, OW = 5, CW = 6, LM = 4, UVF = 3;
  localparam int LONG = OW * LM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, trig = 1'b0, m1 = 1'b0, m2 = 1'b0;
  logic uv = 1'b0, lhi = 1'b0, llo = 1'b0;
  logic rst_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wwd_supervisor #(
    .RD_TICKS(RD), .IW_TICKS(IW), .OW_TICKS(OW), .CW_TICKS(CW),
    .LONG_MULT(LM), .UV_FILT(UVF)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .trig_i(trig),
    .mode_p1_i(m1), .mode_p2_i(m2), .uv_i(uv),
    .load_hi_i(lhi), .load_lo_i(llo), .rst_n_o(rst_n)
  );

  task automatic chk(string req, logic exp);
    n_chk++;
    if (rst_n !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_n_o actual=%0b expected=%0b at %0t", req, rst_n, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      cyc(3);
    end
  endtask

  task automatic smp(logic v);
    trig = v;
    tk(1);
    trig = 1'b0;
  endtask

  task automatic pattern();
    smp(1); smp(1); smp(0); smp(0);
  endtask

  task automatic do_reset(logic p1, logic p2);
    rst = 1'b1; m1 = p1; m2 = p2; trig = 0; uv = 0; lhi = 0; llo = 0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  initial begin
    @(negedge clk);
    // fast mode 00
    do_reset(0, 0);
    chk("R2 reset state", 0);
    tk(RD - 1); chk("R2 before delay", 0);
    tk(1);      chk("R2 release", 1);
    // ignore window swallows a pattern
    pattern();  chk("R3 ignored trigger", 1);
    tk(IW - 4);
    tk(LONG - 1); chk("R4 long window not yet over", 1);
    tk(1);        chk("R4 long window expiry", 0);
    // failure recovery
    tk(RD - 1); chk("R11 hold after failure", 0);
    tk(1);      chk("R11 release after failure", 1);
    tk(IW);
    pattern();  chk("R5 trigger in long window", 1);
    // fourth-sample rule: closed steps 1..2 low, 3 H, 4 H, 5 L, 6 L (closing step)
    smp(0); smp(0); smp(1); smp(1); smp(0); smp(0);
    chk("R7 fourth sample on closing step", 1);
    pattern();  chk("R6 pretrigger in closed window", 0);
    tk(RD);     chk("R11 release after pretrigger", 1);
    tk(IW);
    pattern();  chk("R5 long-window trigger", 1);
    tk(CW);
    pattern();  chk("R5 normal open trigger", 1);
    tk(CW);
    tk(OW - 1); chk("R5 open not yet over", 1);
    tk(1);      chk("R5 open expiry", 0);
    tk(RD);     chk("R2 release before uv", 1);
    // uv glitch sweep below filter length
    for (int len = 1; len < UVF; len++) begin
      uv = 1; cyc(len); uv = 0; cyc(3);
      chk("R8 short glitch ignored", 1);
    end
    uv = 1; cyc(UVF); cyc(1);
    chk("R8 filtered uv", 0);
    tk(RD + 2); chk("R9 held during uv", 0);
    uv = 0; cyc(2);
    tk(RD - 1); chk("R9 delay after recovery", 0);
    tk(1);      chk("R9 release after recovery", 1);
    // load deactivation
    llo = 1; cyc(1); llo = 0; cyc(2);
    tk(IW + LONG + 10); chk("R10 watchdog off keeps high", 1);
    lhi = 1; cyc(1); lhi = 0; cyc(2);
    tk(IW + LONG - 1); chk("R10 restart ignore+long", 1);
    tk(1);             chk("R10 long window after restart", 0);
    // mode 11: off, slow reset
    do_reset(1, 1);
    tk(2 * RD - 1); chk("R1 mode11 slow delay", 0);
    tk(1);          chk("R1 mode11 release", 1);
    tk(2 * (IW + LONG) + 4); chk("R1 mode11 watchdog off", 1);
    // mode 10: fast watchdog, slow reset
    do_reset(1, 0);
    tk(2 * RD - 1); chk("R1 mode10 slow delay", 0);
    tk(1);          chk("R1 mode10 release", 1);
    tk(IW + LONG - 1); chk("R1 mode10 fast windows", 1);
    tk(1);             chk("R1 mode10 expiry", 0);
    // mode 01: slow both
    do_reset(0, 1);
    tk(2 * RD - 1); chk("R1 mode01 slow delay", 0);
    tk(1);          chk("R1 mode01 release", 1);
    tk(2 * (IW + LONG) - 1); chk("R1 mode01 slow windows", 1);
    tk(1);                   chk("R1 mode01 expiry", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule